// File: doc/BRIEF.md
# Signed Non-Restoring Long Divider

This block divides a signed dividend of twice the word width by a signed one-word divisor. It returns a one-word quotient, a one-word remainder and four condition flags. The core runs a four-quadrant non-restoring iteration, so operands of either sign go straight in with no conversion to magnitude. A short controller steps through a handful of states: accept, a probe cycle that screens for overflow, one cycle per quotient bit, a correction cycle, and a result-hold state. With the default parameter the dividend is 32 bits and the divisor is 16 bits.

Operands enter on a valid/ready stream and results leave on another. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the result has been taken. A result is offered with `out_valid`. It stays valid and unchanged until `out_ready` is seen high, which frees the block for the next request. The producer may hold a request for as long as it wants, and the consumer may stall a result for as long as it wants.

The most negative word value has no positive counterpart, so it needs care. It is a legal divisor even when the dividend's top two bits differ. A quotient equal to that value is a legal result and never raises overflow.

Top module: `sdiv_nr`

## Requirements
- R1: `in_ready` is high only when no operation is running and no result is waiting. Operands are captured on an edge with `in_valid` and `in_ready` both high, and `in_ready` is low on the next cycle.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_quot`, `out_rem` and `out_flags` hold their values. The result is consumed on an edge with `out_valid` and `out_ready` both high.
- R3: When the divisor is nonzero and the true quotient fits in W signed bits, `out_quot` is the quotient rounded toward zero. `out_rem` is dividend minus quotient times divisor. It is either zero or carries the dividend's sign.
- R4: `out_flags` bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. On a successful division N equals the quotient's sign bit, Z is 1 exactly when the quotient is zero, and V and C are 0.
- R5: A zero divisor gives flags 4'b0011. It leaves `out_quot` and `out_rem` equal to their values from the previous result.
- R6: Whenever the divisor is nonzero and the true quotient lies outside the W-bit signed range, the flags are 4'b0010. Quotient and remainder are then undefined.
- R7: If dividend bits 2W-1 and 2W-2 differ and the divisor is not the most negative value, overflow is flagged after the probe cycle, and no iterations run.
- R8: If the dividend's magnitude is at least the divisor's magnitude times 2^W, overflow is flagged after the probe cycle.
- R9: Any other overflow is caught after quotient correction, by a range test on the corrected quotient. In that case `out_quot` and `out_rem` may both be rewritten.
- R10: `out_valid` rises after the 1st rising edge that follows the accepting edge when the divisor is zero or R7 or R8 applies. Otherwise it rises after the (W+2)th.
- R11: With the most negative divisor, a dividend whose low W bits are zero and whose quotient fits gives that quotient with remainder 0. A dividend of 2^(2W-2)+n, with 0 <= n < 2^(W-1), gives the most negative quotient, remainder n, and V=0.
- R12: After reset `in_ready` is 1, and `out_valid`, `out_quot`, `out_rem` and `out_flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Request holds operands |
| in_ready | output | 1 | Block can take a request |
| in_dividend | input | 2W | Signed dividend |
| in_divisor | input | W | Signed divisor |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_quot | output | W | Signed quotient |
| out_rem | output | W | Signed remainder |
| out_flags | output | 4 | {N, Z, V, C} |

## Verification
The assertions assume that operands need to be valid only on the accepting edge. They also assume `out_ready` is a plain level that may change in any cycle, with no rule on how long it stays low. The stimulus changes inputs only at falling edges and drops `in_valid` right after acceptance. It stalls some results by holding `out_ready` low for several cycles, which exercises the hold rule. With W=4 the bench tries every dividend against every divisor, so every early, late and most-negative case comes up. The expected results come from integer division in the bench.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_ITER,
    ST_FIX,
    ST_DONE
  } sdiv_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } sdiv_flags_t;
endpackage

// File: rtl/sdiv_screen.sv
// Operand screening done before any iteration.
module sdiv_screen #(
  parameter int W = 16
) (
  input  logic [1:0]   dvd_top,
  input  logic [W-1:0] dvs,
  output logic         dvs_zero,
  output logic         hi_ovf
);
  localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};

  logic dvs_minneg;

  always_comb begin
    dvs_zero   = (dvs == '0);
    dvs_minneg = (dvs == MINNEG);
    // Top two bits differing means |dividend| >= 2^(2W-2); only the most
    // negative divisor can keep such a quotient in range.
    hi_ovf     = (dvd_top[1] ^ dvd_top[0]) && !dvs_minneg;
  end
endmodule

// File: rtl/sdiv_step.sv
// One non-restoring step: move the partial remainder toward zero.
module sdiv_step #(
  parameter int PW = 34
) (
  input  logic [PW-1:0] p_i,
  input  logic [PW-1:0] dsh_i,
  input  logic          dneg_i,
  output logic [PW-1:0] p_o,
  output logic          plus_o
);
  always_comb begin
    plus_o = (p_i[PW-1] == dneg_i);
    p_o    = plus_o ? (p_i - dsh_i) : (p_i + dsh_i);
  end
endmodule

// File: rtl/sdiv_fixup.sv
// Final correction toward truncating results plus range test.
module sdiv_fixup #(
  parameter int W = 16
) (
  input  logic [W:0]   p_i,
  input  logic [W+1:0] q_i,
  input  logic [W-1:0] dvs_i,
  input  logic         dvd_neg_i,
  output logic [W+1:0] q_o,
  output logic [W:0]   r_o,
  output logic         ovf_o
);
  localparam int QW = W + 2;

  logic [W:0] dext;
  logic       p_neg;
  logic       p_zero;

  always_comb begin
    dext   = {dvs_i[W-1], dvs_i};
    p_neg  = p_i[W];
    p_zero = (p_i == '0);
    q_o    = q_i;
    r_o    = p_i;
    if (!p_zero && (p_neg != dvd_neg_i)) begin
      if (p_neg == dvs_i[W-1]) begin
        r_o = p_i - dext;
        q_o = q_i + QW'(1);
      end else begin
        r_o = p_i + dext;
        q_o = q_i - QW'(1);
      end
    end else if (p_i == dext) begin
      r_o = '0;
      q_o = q_i + QW'(1);
    end else if (p_i == -dext) begin
      r_o = '0;
      q_o = q_i - QW'(1);
    end
    ovf_o = !((&q_o[QW-1:W-1]) || !(|q_o[QW-1:W-1]));
  end
endmodule

// File: rtl/sdiv_nr.sv
module sdiv_nr
  import sdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2*W-1:0]   in_dividend,
  input  logic [W-1:0]     in_divisor,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_quot,
  output logic [W-1:0]     out_rem,
  output logic [3:0]       out_flags
);
  localparam int DW = 2 * W;
  localparam int PW = DW + 2;
  localparam int QW = W + 2;
  localparam logic [QW-1:0] WGT0 = QW'(1) << (W - 1);

  sdiv_state_e   state_q;
  logic [PW-1:0] p_q;
  logic [PW-1:0] dsh_q;
  logic [W-1:0]  dvs_q;
  logic          dvd_neg_q;
  logic [QW-1:0] qacc_q;
  logic [QW-1:0] wgt_q;
  logic [W-1:0]  quot_q;
  logic [W-1:0]  rem_q;
  sdiv_flags_t   flags_q;

  logic          dvs_zero;
  logic          hi_ovf;
  logic [PW-1:0] step_p;
  logic          step_plus;
  logic          probe_ovf;
  logic [QW-1:0] q_fix;
  logic [W:0]    r_fix;
  logic          ovf_fix;
  logic [PW-1:0] dvs_ext;

  sdiv_screen #(.W(W)) u_screen (
    .dvd_top  (p_q[DW-1:DW-2]),
    .dvs      (dvs_q),
    .dvs_zero (dvs_zero),
    .hi_ovf   (hi_ovf)
  );

  sdiv_step #(.PW(PW)) u_step (
    .p_i    (p_q),
    .dsh_i  (dsh_q),
    .dneg_i (dvs_q[W-1]),
    .p_o    (step_p),
    .plus_o (step_plus)
  );

  sdiv_fixup #(.W(W)) u_fixup (
    .p_i       (p_q[W:0]),
    .q_i       (qacc_q),
    .dvs_i     (dvs_q),
    .dvd_neg_i (dvd_neg_q),
    .q_o       (q_fix),
    .r_o       (r_fix),
    .ovf_o     (ovf_fix)
  );

  // Probe with divisor*2^W: no sign flip (or zero) means |quotient| >= 2^W.
  always_comb begin
    probe_ovf = (step_p == '0) || (step_p[PW-1] == p_q[PW-1]);
    dvs_ext   = {{(PW-W){in_divisor[W-1]}}, in_divisor};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      p_q       <= '0;
      dsh_q     <= '0;
      dvs_q     <= '0;
      dvd_neg_q <= 1'b0;
      qacc_q    <= '0;
      wgt_q     <= '0;
      quot_q    <= '0;
      rem_q     <= '0;
      flags_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            p_q       <= {{(PW-DW){in_dividend[DW-1]}}, in_dividend};
            dsh_q     <= dvs_ext << W;
            dvs_q     <= in_divisor;
            dvd_neg_q <= in_dividend[DW-1];
            state_q   <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (dvs_zero) begin
            flags_q <= '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b1};
            state_q <= ST_DONE;
          end else if (hi_ovf || probe_ovf) begin
            flags_q <= '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b0};
            state_q <= ST_DONE;
          end else begin
            dsh_q   <= PW'($signed(dsh_q) >>> 1);
            qacc_q  <= '0;
            wgt_q   <= WGT0;
            state_q <= ST_ITER;
          end
        end
        ST_ITER: begin
          p_q    <= step_p;
          qacc_q <= step_plus ? (qacc_q + wgt_q) : (qacc_q - wgt_q);
          dsh_q  <= PW'($signed(dsh_q) >>> 1);
          wgt_q  <= wgt_q >> 1;
          if (wgt_q[0]) state_q <= ST_FIX;
        end
        ST_FIX: begin
          quot_q <= q_fix[W-1:0];
          rem_q  <= r_fix[W-1:0];
          if (ovf_fix)
            flags_q <= '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b0};
          else
            flags_q <= '{n: q_fix[W-1], z: (q_fix[W-1:0] == '0), v: 1'b0, c: 1'b0};
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign out_quot  = quot_q;
  assign out_rem   = rem_q;
  assign out_flags = flags_q;

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_quot) &&
                               $stable(out_rem) && $stable(out_flags));

  p_rem_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIX) && !ovf_fix && (r_fix != '0) |-> r_fix[W] == dvd_neg_q);

  p_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_flags[1] |->
      (out_flags[3] == out_quot[W-1]) && (out_flags[2] == (out_quot == '0)));

  p_div0_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROBE) && dvs_zero |=>
      $stable(out_quot) && $stable(out_rem) && (out_flags == 4'b0011));
endmodule

// File: tb/sdiv_nr_tb.sv
module sdiv_nr_tb_top;
  localparam int W = 4;
  localparam int DW = 2 * W;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_dividend = '0;
  logic [W-1:0]  in_divisor = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_quot;
  logic [W-1:0]  out_rem;
  logic [3:0]    out_flags;

  int checks = 0;
  int failures = 0;
  int prev_q = 0;
  int prev_r = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdiv_nr #(.W(W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_dividend (in_dividend),
    .in_divisor  (in_divisor),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_quot    (out_quot),
    .out_rem     (out_rem),
    .out_flags   (out_flags)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_one(input int dvd, input int dvs, input bit stall);
    int lat;
    int q_exp, r_exp, lat_exp;
    int q_act, r_act;
    bit ovf, early, top_diff;
    logic [DW-1:0] dvd_bits;
    logic [3:0] f_exp;
    string tag;
    logic [W-1:0] hq, hr;
    logic [3:0] hf;
    dvd_bits = dvd[DW-1:0];
    @(negedge clk);
    in_dividend = dvd_bits;
    in_divisor  = dvs[W-1:0];
    in_valid    = 1'b1;
    out_ready   = !stall;
    chk(in_ready == 1'b1, "R1", "in_ready idle", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R1", "in_ready busy", in_ready, 0);
    lat = 0;
    while (!out_valid) begin
      @(negedge clk);
      lat++;
    end
    top_diff = dvd_bits[DW-1] != dvd_bits[DW-2];
    if (dvs != 0) begin
      q_exp = dvd / dvs;
      r_exp = dvd % dvs;
    end else begin
      q_exp = 0;
      r_exp = 0;
    end
    ovf   = (dvs != 0) && ((q_exp < -(1 << (W-1))) || (q_exp > (1 << (W-1)) - 1));
    early = (dvs == 0) || (top_diff && dvs != -(1 << (W-1))) ||
            ((dvd < 0 ? -dvd : dvd) >= (dvs < 0 ? -dvs : dvs) * (1 << W));
    lat_exp = early ? 1 : W + 2;
    q_act = int'($signed(out_quot));
    r_act = int'($signed(out_rem));
    if (dvs == 0) begin
      tag = "R5";
      f_exp = 4'b0011;
      chk(q_act == prev_q, tag, "quot kept", q_act, prev_q);
      chk(r_act == prev_r, tag, "rem kept", r_act, prev_r);
    end else if (ovf) begin
      if (early && top_diff && dvs != -(1 << (W-1))) tag = "R7";
      else if (early) tag = "R8";
      else tag = "R9";
      f_exp = 4'b0010;
    end else begin
      tag = (dvs == -(1 << (W-1))) ? "R11" : "R3";
      f_exp = {q_exp < 0, q_exp == 0, 2'b00};
      chk(q_act == q_exp, tag, "quotient", q_act, q_exp);
      chk(r_act == r_exp, tag, "remainder", r_act, r_exp);
    end
    chk(out_flags == f_exp, ovf ? "R6" : ((dvs == 0) ? "R5" : "R4"),
        "flags", out_flags, f_exp);
    chk(lat == lat_exp, ovf || dvs == 0 ? tag : "R10", "latency", lat, lat_exp);
    if (stall) begin
      hq = out_quot;
      hr = out_rem;
      hf = out_flags;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(out_valid && out_quot == hq && out_rem == hr && out_flags == hf,
            "R2", "held under stall", out_valid, 1);
        chk(in_ready == 1'b0, "R1", "no accept while result waits", in_ready, 0);
      end
      out_ready = 1'b1;
    end
    prev_q = q_act;
    prev_r = r_act;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: state straight after reset
    chk(in_ready == 1'b1, "R12", "in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R12", "out_valid", out_valid, 0);
    chk(out_quot == '0, "R12", "out_quot", out_quot, 0);
    chk(out_rem == '0, "R12", "out_rem", out_rem, 0);
    chk(out_flags == '0, "R12", "out_flags", out_flags, 0);
    n = 0;
    for (int dvs = -(1 << (W-1)); dvs < (1 << (W-1)); dvs++) begin
      for (int dvd = -(1 << (DW-1)); dvd < (1 << (DW-1)); dvd++) begin
        run_one(dvd, dvs, (n % 61) == 7);
        n++;
      end
    end
    // R11 spot cases named explicitly
    run_one((1 << (DW-2)) + 3, -(1 << (W-1)), 1'b0);
    run_one(-2 * (1 << (W-1)) * 2, -(1 << (W-1)), 1'b0);
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule